// File: doc/BRIEF.md
# Cascadable Dual Timer Clock Selector

This block produces the count-enable pulses for a pair of 8-bit timer channels and keeps each channel's counter, two compare registers and status flags. Each channel has a 3-bit clock-select field. It chooses between no counting, three prescaled versions of the system clock, a cascade event taken from the partner channel, and an external clock pin sampled on its rising edge, its falling edge or both edges. The channels can be chained: channel 0 can advance on each overflow of channel 1, and channel 1 can advance on each compare-match A of channel 0. If both channels select the cascade source, the two would feed each other, so that setting produces no counting at all.

A single register port gives read and write access to every channel register. Address bit 3 picks the channel and bits 2:0 pick the register. The compare-match and overflow flags are set by hardware and stay set until software writes a zero to them.

Top module: `twin_timer_clock`

## Requirements
- R1: After reset every register reads as follows (channel c at address 8*c+n): clock select (n=0) 0x00, channel 0 status (n=1) 0x00, channel 1 status 0x10, counter (n=2) 0x00, compare A (n=3) 0xFF, compare B (n=4) 0xFF.
- R2: With clock-select code 000 a channel's counter never advances, whatever the pin and prescaler do.
- R3: Codes 001, 010 and 011 advance the counter exactly once every 8, 64 and 8192 system clock cycles, on the falling edge of the divided clock.
- R4: Code 101 advances the counter once per rising edge of the external pin, code 110 once per falling edge, and code 111 once per edge of either kind.
- R5: With code 100, channel 0 advances once per overflow of channel 1.
- R6: With code 100, channel 1 advances once per compare-match A of channel 0.
- R7: When both channels hold code 100 together, neither counter advances.
- R8: Status bit 5 is set when a count step takes the counter from 0xFF to 0x00.
- R9: Status bit 6 (or bit 7) is set when a count step makes the counter equal to compare A (or compare B).
- R10: Writing 0 to status bits 7..5 clears them and writing 1 leaves them as they are. A hardware set in the same cycle as a clearing write leaves the flag set.
- R11: Status bits 3..0 are read/write on both channels. Bit 4 is read/write on channel 0. On channel 1 bit 4 always reads 1 and ignores writes.
- R12: The counter and both compare registers are read/write. A write to the counter loads the written value in place of that cycle's count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extPin | input | 1 | External count clock, asynchronous to clk |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register address: bit 3 channel, bits 2:0 register |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data for busAddr, combinational |

## Verification
Each prescaled code is run until the spacing between two successive counter changes can be measured. This separates the three divide ratios and exposes a wrong tap or an off-by-one edge detector. The external pin is driven with bursts of clean pulses under each edge mode, and the rising, falling and both-edge settings give distinct counts. Cascade is exercised by forcing channel 0 compare-A matches and channel 1 overflows with preloaded counters, so each chained advance can be counted. Flag tests place the counter one step below the wrap and compare values, and one test puts a clearing write on the exact cycle of a hardware set.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int NumCh = 2;
  localparam int RegW  = 8;
  localparam int SelW  = 3;

  typedef enum logic [SelW-1:0] {
    SEL_OFF      = 3'd0,
    SEL_DIV8     = 3'd1,
    SEL_DIV64    = 3'd2,
    SEL_DIV8K    = 3'd3,
    SEL_CASC     = 3'd4,
    SEL_EXT_RISE = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_BOTH = 3'd7
  } clkSrc_e;

  typedef enum logic [2:0] {
    REG_SEL  = 3'd0,
    REG_STAT = 3'd1,
    REG_CNT  = 3'd2,
    REG_CMPA = 3'd3,
    REG_CMPB = 3'd4
  } regIdx_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NumCh-1:0] countEn;
  } ctlStrobe_t;
endpackage

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int PRESC_W   = 13,
  parameter int TAP_DIV8  = 2,
  parameter int TAP_DIV64 = 5,
  parameter int TAP_DIV8K = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        extPin,
  input  logic [NumCh-1:0][SelW-1:0]  clkSel,
  input  logic [NumCh-1:0]            cascEvt,
  output ctlStrobe_t                  strobe
);
  localparam int NumTap = 3;

  function automatic int tapPos(input int idx);
    case (idx)
      0:       return TAP_DIV8;
      1:       return TAP_DIV64;
      default: return TAP_DIV8K;
    endcase
  endfunction

  // free-running prescaler; a tap falling 1->0 yields one enable cycle
  logic [PRESC_W-1:0] presc;
  logic [NumTap-1:0]  tapNow, tapPrev, tick;

  for (genvar t = 0; t < NumTap; t++) begin : g_tap
    assign tapNow[t] = presc[tapPos(t)];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc   <= '0;
      tapPrev <= '0;
    end else begin
      presc   <= presc + PRESC_W'(1);
      tapPrev <= tapNow;
    end
  end

  assign tick = tapPrev & ~tapNow;

  // two-flop synchronizer plus one history flop for edge detection
  logic syncA, syncB, syncC;
  logic pinRise, pinFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= extPin;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign pinRise = syncB & ~syncC;
  assign pinFall = ~syncB & syncC;

  // both channels chained onto each other would form a loop
  logic loopLock;
  assign loopLock = (clkSel[0] == SEL_CASC) && (clkSel[1] == SEL_CASC);

  logic [NumCh-1:0] enVec;

  for (genvar c = 0; c < NumCh; c++) begin : g_sel
    logic src;
    always_comb begin
      case (clkSel[c])
        SEL_DIV8:     src = tick[0];
        SEL_DIV64:    src = tick[1];
        SEL_DIV8K:    src = tick[2];
        SEL_CASC:     src = cascEvt[NumCh-1-c];
        SEL_EXT_RISE: src = pinRise;
        SEL_EXT_FALL: src = pinFall;
        SEL_EXT_BOTH: src = pinRise | pinFall;
        default:      src = 1'b0;
      endcase
    end
    assign enVec[c] = src & ~loopLock;
  end

  assign strobe.countEn = enVec;
endmodule

// File: rtl/twin_timer_dp.sv
module twin_timer_dp
  import twin_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobe_t                  strobe,
  input  logic                        busWrEn,
  input  logic [3:0]                  busAddr,
  input  logic [RegW-1:0]             busWrData,
  output logic [RegW-1:0]             busRdData,
  output logic [NumCh-1:0][SelW-1:0]  clkSel,
  output logic [NumCh-1:0]            cascEvt,
  output logic [NumCh-1:0][CNT_W-1:0] cntVal,
  output logic [NumCh-1:0][2:0]       flagVal
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [2:0]                  regSel;
  logic [NumCh-1:0][RegW-1:0]  rdCh;

  assign regSel = busAddr[2:0];

  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    logic              chHit, wrSel, wrStat, wrCnt, wrCmpA, wrCmpB, step;
    logic [SelW-1:0]   selQ;
    logic [CNT_W-1:0]  cntQ, cmpAQ, cmpBQ, cntInc;
    logic [2:0]        flagQ, flagSet, flagKeep;   // {cmpB, cmpA, ovf}
    logic [3:0]        outSelQ;
    logic              auxQ, cascQ;

    assign chHit  = busWrEn && (int'(busAddr[3]) == c);
    assign wrSel  = chHit && (regSel == REG_SEL);
    assign wrStat = chHit && (regSel == REG_STAT);
    assign wrCnt  = chHit && (regSel == REG_CNT);
    assign wrCmpA = chHit && (regSel == REG_CMPA);
    assign wrCmpB = chHit && (regSel == REG_CMPB);

    assign step     = strobe.countEn[c] && !wrCnt;
    assign cntInc   = cntQ + CNT_W'(1);
    assign flagSet  = {step && (cntInc == cmpBQ),
                       step && (cntInc == cmpAQ),
                       step && (cntQ == CntMax)};
    assign flagKeep = wrStat ? busWrData[7:5] : 3'b111;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selQ    <= '0;
        cntQ    <= '0;
        cmpAQ   <= '1;
        cmpBQ   <= '1;
        flagQ   <= '0;
        outSelQ <= '0;
        cascQ   <= 1'b0;
      end else begin
        if (wrSel)       selQ <= busWrData[SelW-1:0];
        if (wrCnt)       cntQ <= busWrData[CNT_W-1:0];
        else if (step)   cntQ <= cntInc;
        if (wrCmpA)      cmpAQ <= busWrData[CNT_W-1:0];
        if (wrCmpB)      cmpBQ <= busWrData[CNT_W-1:0];
        flagQ <= flagSet | (flagQ & flagKeep);
        if (wrStat)      outSelQ <= busWrData[3:0];
        // channel 0 hands compare-A to its partner, channel 1 hands overflow
        cascQ <= (c == 0) ? flagSet[1] : flagSet[0];
      end
    end

    if (c == 0) begin : g_aux
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       auxQ <= 1'b0;
        else if (wrStat) auxQ <= busWrData[4];
      end
    end else begin : g_fixed
      assign auxQ = 1'b1;
    end

    always_comb begin
      case (regSel)
        REG_SEL:  rdCh[c] = RegW'(selQ);
        REG_STAT: rdCh[c] = {flagQ, auxQ, outSelQ};
        REG_CNT:  rdCh[c] = RegW'(cntQ);
        REG_CMPA: rdCh[c] = RegW'(cmpAQ);
        REG_CMPB: rdCh[c] = RegW'(cmpBQ);
        default:  rdCh[c] = '0;
      endcase
    end

    assign clkSel[c]  = selQ;
    assign cascEvt[c] = cascQ;
    assign cntVal[c]  = cntQ;
    assign flagVal[c] = flagQ;
  end

  assign busRdData = rdCh[busAddr[3]];
endmodule

// File: rtl/twin_timer_clock.sv
module twin_timer_clock
  import twin_timer_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PRESC_W   = 13,
  parameter int TAP_DIV8  = 2,
  parameter int TAP_DIV64 = 5,
  parameter int TAP_DIV8K = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            extPin,
  input  logic            busWrEn,
  input  logic [3:0]      busAddr,
  input  logic [RegW-1:0] busWrData,
  output logic [RegW-1:0] busRdData
);
  ctlStrobe_t                   strobe;
  logic [NumCh-1:0][SelW-1:0]   clkSel;
  logic [NumCh-1:0]             cascEvt;
  logic [NumCh-1:0][CNT_W-1:0]  cntVal;
  logic [NumCh-1:0][2:0]        flagVal;

  twin_timer_ctrl #(
    .PRESC_W  (PRESC_W),
    .TAP_DIV8 (TAP_DIV8),
    .TAP_DIV64(TAP_DIV64),
    .TAP_DIV8K(TAP_DIV8K)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .extPin (extPin),
    .clkSel (clkSel),
    .cascEvt(cascEvt),
    .strobe (strobe)
  );

  twin_timer_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .clkSel   (clkSel),
    .cascEvt  (cascEvt),
    .cntVal   (cntVal),
    .flagVal  (flagVal)
  );
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk
  import twin_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busWrEn,
  input logic [3:0]                  busAddr,
  input logic [RegW-1:0]             busRdData,
  input logic [NumCh-1:0][SelW-1:0]  clkSel,
  input logic [NumCh-1:0]            countEn,
  input logic [NumCh-1:0][CNT_W-1:0] cnt,
  input logic [NumCh-1:0][2:0]       flags
);
  assert_cascade_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel[0] == SEL_CASC && clkSel[1] == SEL_CASC) |-> (countEn == '0));

  assert_unused_bit_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 4'd9) |-> busRdData[4]);

  for (genvar c = 0; c < NumCh; c++) begin : g_chk
    logic cntWr, statWr;
    assign cntWr  = busWrEn && (int'(busAddr[3]) == c) && (busAddr[2:0] == REG_CNT);
    assign statWr = busWrEn && (int'(busAddr[3]) == c) && (busAddr[2:0] == REG_STAT);

    assert_disabled_R2: assert property (@(posedge clk) disable iff (!rstN)
      (clkSel[c] == SEL_OFF && !cntWr) |=> (cnt[c] == $past(cnt[c])));

    assert_single_step_R12: assert property (@(posedge clk) disable iff (!rstN)
      (countEn[c] && !cntWr) |=> (cnt[c] == $past(cnt[c]) + CNT_W'(1)));

    assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
      (countEn[c] && !cntWr && cnt[c] == '1) |=> flags[c][0]);

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
      !statWr |=> ((flags[c] & $past(flags[c])) == $past(flags[c])));
  end
endmodule

bind twin_timer_clock twin_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busRdData(busRdData),
  .clkSel   (clkSel),
  .countEn  (strobe.countEn),
  .cnt      (cntVal),
  .flags    (flagVal)
);

// File: tb/twin_timer_clock_tb.sv
`timescale 1ns/1ps
module twin_timer_clock_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extPin = 1'b0;
  logic       busWrEn = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  twin_timer_clock u_dut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    busWrEn = 1'b0;
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); extPin = 1'b1;
    repeat (6) @(negedge clk);
    extPin = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic expectReg(input string tag, input logic [3:0] a, input int exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, int'(v), exp);
  endtask

  // spacing in cycles between two successive changes of counter 0
  task automatic gap(input int lim, output int g);
    logic [7:0] v, prev;
    int n;
    rd(4'd2, prev);
    n = 0;
    do begin rd(4'd2, v); n++; end while (v == prev && n < lim);
    prev = v; g = 0;
    do begin rd(4'd2, v); g++; end while (v == prev && g < lim);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int g;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    for (int c = 0; c < 2; c++) begin
      expectReg("R1 sel", 4'(8*c),     0);
      expectReg("R1 stat", 4'(8*c + 1), (c == 1) ? 'h10 : 'h00);
      expectReg("R1 cnt", 4'(8*c + 2), 0);
      expectReg("R1 cmpA", 4'(8*c + 3), 'hFF);
      expectReg("R1 cmpB", 4'(8*c + 4), 'hFF);
    end

    // R2 disabled: no advance over many prescaler periods and pin edges
    pulse(); pulse();
    repeat (100) @(negedge clk);
    expectReg("R2 ch0 off", 4'd2, 0);

    // R3 prescaled spacing
    for (int code = 1; code <= 3; code++) begin
      int div;
      div = (code == 1) ? 8 : (code == 2) ? 64 : 8192;
      wr(4'd0, 8'(code));
      gap(3 * div, g);
      check($sformatf("R3 code %0d spacing", code), g, div);
    end

    // R4 external edge modes; ch1 stays off (R2)
    for (int m = 5; m <= 7; m++) begin
      int k, exp;
      k = m - 2;
      exp = (m == 7) ? 2 * k : k;
      wr(4'd0, 8'd0);
      wr(4'd2, 8'd0);
      wr(4'd0, 8'(m));
      for (int p = 0; p < k; p++) pulse();
      expectReg($sformatf("R4 mode %0d count", m), 4'd2, exp);
    end
    expectReg("R2 ch1 off during pulses", 4'd10, 0);

    // R8 overflow flag
    wr(4'd0, 8'd5);
    wr(4'd3, 8'h40);
    wr(4'd4, 8'h80);
    wr(4'd1, 8'h00);
    wr(4'd2, 8'hFE);
    pulse();
    expectReg("R8 no flag at FF", 4'd1, 'h00);
    pulse();
    expectReg("R8 wrap sets bit5", 4'd1, 'h20);
    expectReg("R8 wrapped count", 4'd2, 'h00);

    // R9 compare flags
    wr(4'd2, 8'h3E);
    pulse();
    expectReg("R9 before match A", 4'd1, 'h20);
    pulse();
    expectReg("R9 match A bit6", 4'd1, 'h60);
    wr(4'd2, 8'h7F);
    pulse();
    expectReg("R9 match B bit7", 4'd1, 'hE0);

    // R10 write-one keeps, write-zero clears, set beats clear
    wr(4'd1, 8'hFF);
    expectReg("R10 ones keep flags", 4'd1, 'hFF);
    wr(4'd1, 8'h7F);
    expectReg("R10 zero clears bit7", 4'd1, 'h7F);
    wr(4'd2, 8'h3F);
    @(negedge clk); extPin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busAddr = 4'd1; busWrData = 8'h00; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    repeat (6) @(negedge clk);
    extPin = 1'b0;
    repeat (6) @(negedge clk);
    expectReg("R10 set wins over clear", 4'd1, 'h40);

    // R11 control bits
    wr(4'd1, 8'h1F);
    expectReg("R11 ch0 bits4..0", 4'd1, 'h1F);
    wr(4'd9, 8'h0A);
    expectReg("R11 ch1 bit4 fixed", 4'd9, 'h1A);
    wr(4'd9, 8'h00);
    expectReg("R11 ch1 reads 0x10", 4'd9, 'h10);

    // R12 plain read/write registers
    wr(4'd12, 8'h5A);
    expectReg("R12 cmpB1", 4'd12, 'h5A);
    wr(4'd11, 8'hA5);
    expectReg("R12 cmpA1", 4'd11, 'hA5);
    wr(4'd10, 8'h33);
    expectReg("R12 cnt1", 4'd10, 'h33);

    // R6 channel 1 follows channel 0 compare-A (cmpA0 = 0x40, ch0 rising)
    wr(4'd10, 8'h00);
    wr(4'd8, 8'd4);
    for (int p = 0; p < 3; p++) begin
      wr(4'd2, 8'h3F);
      pulse();
    end
    expectReg("R6 cascade count", 4'd10, 3);

    // R5 channel 0 follows channel 1 overflow
    wr(4'd8, 8'd5);
    wr(4'd0, 8'd4);
    wr(4'd2, 8'h00);
    for (int p = 0; p < 2; p++) begin
      wr(4'd10, 8'hFF);
      pulse();
    end
    expectReg("R5 cascade count", 4'd2, 2);
    expectReg("R5 ch1 wrapped", 4'd10, 0);

    // R7 both in cascade: nothing counts
    wr(4'd8, 8'd4);
    wr(4'd2, 8'h10);
    wr(4'd10, 8'h20);
    pulse(); pulse();
    repeat (50) @(negedge clk);
    expectReg("R7 ch0 held", 4'd2, 'h10);
    expectReg("R7 ch1 held", 4'd10, 'h20);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule